// File: doc/BRIEF.md
# Serial Peripheral Master with Byte Queues

This block is a serial peripheral (SPI) bus master that a processor drives through a small byte-wide register port. Bytes that software writes to the data register go into a transmit queue. A shift engine drains that queue one byte at a time. It generates the serial clock from the system clock, and every byte it receives lands in a receive queue, which software empties by reading the same data register.

Software can also ask for reception without supplying data. It writes a byte count, and the engine then shifts out filler bytes of all ones until that many bytes have come back. Mode bits choose the serial clock polarity and phase, the bit order and an internal loopback path. A further mode bit flushes both queues. One of two chip-select lines is driven under register control. The queue flags, with per-flag enables, are merged onto a single interrupt line.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the status register (index 1) reads 0xA0, both chip selects are high, the serial clock is low and the interrupt is low.
- R2: The transmit queue holds 32 bytes. Status bit 6 shows it full. A data write to a full queue is dropped and sets the sticky abort flag, bit 2 of the enable register (index 4). Writing 1 to that bit clears it.
- R3: A read of the data register (index 0) pops the oldest received byte. A read while the receive queue is empty returns 0 and changes nothing. Status bit 5 flags the receive queue empty and bit 4 flags it full.
- R4: Mode register (index 2) bit 5 sets the idle level of the serial clock and bit 4 sets the phase. Data is stable on the capture edge, which is rising when the two bits are equal and falling otherwise.
- R5: Mode bit 3 set sends and receives least significant bit first; clear sends most significant bit first.
- R6: With mode bit 6 set, each transmitted byte comes back unchanged into the receive queue and the external data input is ignored.
- R7: With loopback off, the received byte is built from the external data input.
- R8: A nonzero count written to register index 3 makes the engine send 0xFF filler bytes when the transmit queue is empty. The count drops by one per filler byte received, and filling stops at zero.
- R9: The engine starts no byte while the receive queue is full, so automatic reception pauses without losing data and resumes once a byte is read.
- R10: While mode bit 7 is set, both queues stay empty and data writes are ignored.
- R11: The interrupt is high whenever a status flag in bits 7..4 is set together with the enable bit at the same position.
- R12: A status write with bit 0 set drives low the chip select chosen by bit 3. Bit 1 requests release, which takes effect only once no byte is shifting. At most one chip select is low at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register index |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on data index) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects |

## Verification
The assertions check several rules on every cycle: the serial clock rests at the programmed idle level, the abort flag sets on an overflowing write, empty reads return zero, the receive count never rises except by a write, a flush leaves both queues empty, and chip selects are never released in the middle of a byte or driven two at a time. Bit-level serial timing in all four clock modes, both bit orders, loopback, the pause and resume of automatic reception at a full receive queue, and the interrupt combinations depend on longer sequences. Only the bench scenarios can show those: a bench-side bit monitor on the serial lines and reads through the register port.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [2:0] {
        RA_DATA  = 3'd0,
        RA_STAT  = 3'd1,
        RA_MODE  = 3'd2,
        RA_RXCNT = 3'd3,
        RA_IEN   = 3'd4
    } spim_reg_e;

    typedef struct packed {
        logic flush;
        logic loopback;
        logic cpol;
        logic cpha;
        logic lsb_first;
    } spim_mode_t;

    typedef struct packed {
        logic tx_empty;
        logic tx_full;
        logic rx_empty;
        logic rx_full;
    } spim_flags_t;

    localparam logic [7:0] FILLER_BYTE = 8'hFF;

    function automatic spim_mode_t mode_from_byte(input logic [7:0] b);
        spim_mode_t m;
        m.flush     = b[7];
        m.loopback  = b[6];
        m.cpol      = b[5];
        m.cpha      = b[4];
        m.lsb_first = b[3];
        return m;
    endfunction

    function automatic logic [7:0] mode_to_byte(input spim_mode_t m);
        return {m.flush, m.loopback, m.cpol, m.cpha, m.lsb_first, 3'b000};
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       cpol,
    input  logic       cpha,
    input  logic       lsb_first,
    input  logic       loopback,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);
    localparam int HALF = (CLK_DIV / 2 < 1) ? 1 : CLK_DIV / 2;
    localparam int DCW  = (HALF > 1) ? $clog2(HALF) : 1;

    logic [7:0]     tx_sr, rx_sr;
    logic [DCW-1:0] div_q;
    logic [3:0]     edge_q;
    logic           sclk_q, busy_q, done_q;
    logic           tick, sample_now, shift_now, din;

    assign mosi       = lsb_first ? tx_sr[0] : tx_sr[7];
    assign din        = loopback ? mosi : miso;
    assign tick       = (div_q == DCW'(HALF - 1));
    assign sample_now = (edge_q[0] == cpha);
    assign shift_now  = !sample_now && (edge_q != 4'd0);
    assign busy       = busy_q;
    assign done       = done_q;
    assign rx_byte    = rx_sr;
    assign sclk       = sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr  <= '0;
            rx_sr  <= '0;
            div_q  <= '0;
            edge_q <= '0;
            sclk_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                sclk_q <= cpol;
                if (start) begin
                    busy_q <= 1'b1;
                    tx_sr  <= tx_byte;
                    div_q  <= '0;
                    edge_q <= '0;
                end
            end else if (tick) begin
                div_q  <= '0;
                sclk_q <= ~sclk_q;
                edge_q <= edge_q + 1'b1;
                if (sample_now)
                    rx_sr <= lsb_first ? {din, rx_sr[7:1]} : {rx_sr[6:0], din};
                if (shift_now)
                    tx_sr <= lsb_first ? {1'b0, tx_sr[7:1]} : {tx_sr[6:0], 1'b0};
                if (edge_q == 4'd15) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int CLK_DIV    = 4,
    parameter int NUM_CS     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);
    spim_mode_t  mode_q;
    spim_flags_t flags;
    logic [7:0]  rxcnt_q;
    logic [3:0]  ien_q;
    logic        abort_q, cs_on_q, cs_pend_q, cs_sel_q, cur_dummy_q;

    logic        tx_empty, tx_full, rx_empty, rx_full;
    logic [7:0]  tx_head, rx_head, eng_rx;
    logic        eng_busy, eng_done, eng_start;
    logic        wr_data, wr_stat, wr_mode, wr_cnt, wr_ien, rd_data;

    assign wr_data = bus_wr && (bus_addr == RA_DATA);
    assign wr_stat = bus_wr && (bus_addr == RA_STAT);
    assign wr_mode = bus_wr && (bus_addr == RA_MODE);
    assign wr_cnt  = bus_wr && (bus_addr == RA_RXCNT);
    assign wr_ien  = bus_wr && (bus_addr == RA_IEN);
    assign rd_data = bus_rd && (bus_addr == RA_DATA);

    spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(mode_q.flush),
        .push(wr_data), .wdata(bus_wdata),
        .pop(eng_start && !tx_empty), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(mode_q.flush),
        .push(eng_done), .wdata(eng_rx),
        .pop(rd_data), .rdata(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    assign eng_start = !eng_busy && !eng_done && !mode_q.flush && !rx_full &&
                       (!tx_empty || (rxcnt_q != 8'd0));

    spim_shift #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst(rst), .start(eng_start),
        .tx_byte(tx_empty ? FILLER_BYTE : tx_head),
        .cpol(mode_q.cpol), .cpha(mode_q.cpha),
        .lsb_first(mode_q.lsb_first), .loopback(mode_q.loopback),
        .miso(miso), .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx),
        .sclk(sclk), .mosi(mosi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= '0;
            rxcnt_q     <= '0;
            ien_q       <= '0;
            abort_q     <= 1'b0;
            cs_on_q     <= 1'b0;
            cs_pend_q   <= 1'b0;
            cs_sel_q    <= 1'b0;
            cur_dummy_q <= 1'b0;
        end else begin
            if (wr_mode) mode_q <= mode_from_byte(bus_wdata);
            if (wr_ien)  ien_q  <= bus_wdata[7:4];
            if (eng_start) cur_dummy_q <= tx_empty;

            if (wr_cnt)
                rxcnt_q <= bus_wdata;
            else if (eng_done && cur_dummy_q && rxcnt_q != 8'd0)
                rxcnt_q <= rxcnt_q - 1'b1;

            if (wr_data && tx_full && !mode_q.flush)
                abort_q <= 1'b1;
            else if (wr_ien && bus_wdata[2])
                abort_q <= 1'b0;

            if (cs_pend_q && !eng_busy) begin
                cs_on_q   <= 1'b0;
                cs_pend_q <= 1'b0;
            end
            if (wr_stat) begin
                if (bus_wdata[0]) begin
                    cs_on_q  <= 1'b1;
                    cs_sel_q <= bus_wdata[3];
                end
                if (bus_wdata[1]) cs_pend_q <= 1'b1;
            end
        end
    end

    always_comb begin
        flags.tx_empty = tx_empty;
        flags.tx_full  = tx_full;
        flags.rx_empty = rx_empty;
        flags.rx_full  = rx_full;
    end

    assign irq = |(ien_q & flags);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CS; gi++) begin : g_cs
            assign cs_n[gi] = !(cs_on_q && (cs_sel_q == gi[0]));
        end
    endgenerate

    always_comb begin
        case (bus_addr)
            RA_DATA:  bus_rdata = rx_empty ? 8'h00 : rx_head;
            RA_STAT:  bus_rdata = {flags, cs_sel_q, 1'b0, cs_pend_q, cs_on_q};
            RA_MODE:  bus_rdata = mode_to_byte(mode_q);
            RA_RXCNT: bus_rdata = rxcnt_q;
            RA_IEN:   bus_rdata = {ien_q, 1'b0, abort_q, 2'b00};
            default:  bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic [NUM_CS-1:0] cs_n,
    input logic              sclk,
    input logic              eng_busy,
    input logic              mode_cpol,
    input logic              mode_flush,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              rx_empty,
    input logic              abort_q,
    input logic [7:0]        rxcnt_q
);
    // R2: overflowing data write raises the sticky abort flag
    a_r2_abort_on_full: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0 && tx_full && !mode_flush) |=> abort_q);

    // R3: empty receive queue reads as zero
    a_r3_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd0 && rx_empty) |-> (bus_rdata == 8'h00));

    // R4: idle serial clock sits at the programmed polarity
    a_r4_sclk_idle: assert property (@(posedge clk) disable iff (rst)
        (!eng_busy && !$past(eng_busy)) |-> (sclk == $past(mode_cpol)));

    // R8: receive count only rises through a register write
    a_r8_count_no_rise: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 3'd3) |=> (rxcnt_q <= $past(rxcnt_q)));

    // R10: flush empties both queues
    a_r10_flush_empty: assert property (@(posedge clk) disable iff (rst)
        mode_flush |=> (tx_empty && rx_empty));

    // R12: never two selects at once
    a_r12_cs_single: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);

    // R12: no release while a byte is shifting
    a_r12_cs_hold: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && $past(eng_busy) && $past(cs_n) != {NUM_CS{1'b1}})
        |-> (cs_n != {NUM_CS{1'b1}}));
endmodule

bind spim_ctrl spim_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .cs_n(cs_n), .sclk(sclk),
    .eng_busy(eng_busy), .mode_cpol(mode_q.cpol), .mode_flush(mode_q.flush),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_empty(rx_empty),
    .abort_q(abort_q), .rxcnt_q(rxcnt_q)
);

// File: tb/spim_ctrl_bench.sv
module spim_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, sclk, mosi;
    logic       miso = 1'b0;
    logic [1:0] cs_n;

    int n_checks = 0;
    int n_fail   = 0;

    logic       mon_rise = 1'b1;
    logic [7:0] mon_byte = '0;

    always #4 clk = ~clk;

    spim_ctrl u_spim_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // bit monitor: capture on the edge named by the mode, msb-first assembly
    always @(sclk) begin
        if (sclk === mon_rise) mon_byte <= {mon_byte[6:0], mosi};
    end

    // {mode byte, transmit byte, expected monitor byte}; loopback on in all
    localparam logic [23:0] VEC [6] = '{
        {8'h40, 8'hA5, 8'hA5},
        {8'h50, 8'h3C, 8'h3C},
        {8'h60, 8'h81, 8'h81},
        {8'h70, 8'h5A, 8'h5A},
        {8'h48, 8'h01, 8'h80},
        {8'h78, 8'hC4, 8'h23}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd1, d);  check("R1 status", d, 8'hA0);
        check("R1 cs_n", {6'b0, cs_n}, 8'h03);
        check("R1 sclk", {7'b0, sclk}, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        rd(3'd0, d);  check("R3 empty read", d, 8'h00);

        // R4 R5 R6 table walk, miso held high to prove loopback ignores it
        miso = 1'b1;
        for (int i = 0; i < 6; i++) begin
            mon_rise = (VEC[i][21] == VEC[i][20]);
            wr(3'd2, VEC[i][23:16]);
            idle(4);
            wr(3'd0, VEC[i][15:8]);
            idle(50);
            rd(3'd0, d);  check("R6 loopback data", d, VEC[i][15:8]);
            check("R4 R5 serial bits", mon_byte, VEC[i][7:0]);
            check("R4 idle level", {7'b0, sclk}, {7'b0, VEC[i][21]});
        end

        // R7 external input
        mon_rise = 1'b1;
        wr(3'd2, 8'h00);
        miso = 1'b1; wr(3'd0, 8'h00); idle(50);
        rd(3'd0, d);  check("R7 miso high", d, 8'hFF);
        miso = 1'b0; wr(3'd0, 8'hFF); idle(50);
        rd(3'd0, d);  check("R7 miso low", d, 8'h00);

        // R8 auto receive of three filler bytes
        wr(3'd3, 8'd3);
        idle(130);
        rd(3'd3, d);  check("R8 count reached zero", d, 8'h00);
        check("R8 filler on mosi", mon_byte, 8'hFF);
        for (int i = 0; i < 3; i++) begin
            rd(3'd0, d);  check("R8 received byte", d, 8'h00);
        end
        rd(3'd1, d);  check("R8 exactly three bytes", d, 8'hA0);

        // R9 pause at full receive queue
        miso = 1'b1;
        wr(3'd3, 8'd40);
        idle(1400);
        rd(3'd1, d);  check("R9 rx full", d, 8'h90);
        rd(3'd3, d);  check("R9 count paused", d, 8'd8);
        idle(300);
        rd(3'd3, d);  check("R9 still paused", d, 8'd8);
        for (int i = 0; i < 32; i++) begin
            rd(3'd0, d);  check("R9 no data lost", d, 8'hFF);
        end
        idle(400);
        rd(3'd3, d);  check("R9 resumed to zero", d, 8'd0);
        for (int i = 0; i < 8; i++) begin
            rd(3'd0, d);  check("R9 tail bytes", d, 8'hFF);
        end
        rd(3'd1, d);  check("R9 forty bytes total", d, 8'hA0);

        // R2 fill transmit queue while engine is stalled by a full receive queue
        wr(3'd3, 8'd32);
        idle(1400);
        rd(3'd1, d);  check("R9 stalled", d, 8'h90);
        for (int i = 0; i < 32; i++) wr(3'd0, 8'(i));
        rd(3'd1, d);  check("R2 tx full", d, 8'h50);
        rd(3'd4, d);  check("R2 no abort yet", d, 8'h00);
        wr(3'd0, 8'hEE);
        rd(3'd4, d);  check("R2 abort set", d, 8'h04);
        wr(3'd4, 8'h04);
        rd(3'd4, d);  check("R2 abort cleared", d, 8'h00);

        // R11 interrupt combinations
        wr(3'd4, 8'h40); idle(1);
        check("R11 tx full enabled", {7'b0, irq}, 8'h01);
        wr(3'd4, 8'h80); idle(1);
        check("R11 tx empty enabled", {7'b0, irq}, 8'h00);
        wr(3'd4, 8'h20); idle(1);
        check("R11 rx empty enabled", {7'b0, irq}, 8'h00);

        // R10 flush
        wr(3'd2, 8'h80); idle(1);
        rd(3'd1, d);  check("R10 flushed", d, 8'hA0);
        check("R11 rx empty irq", {7'b0, irq}, 8'h01);
        wr(3'd0, 8'h77);
        rd(3'd1, d);  check("R10 write ignored", d, 8'hA0);
        wr(3'd2, 8'h40);
        idle(60);
        rd(3'd1, d);  check("R10 nothing sent", d, 8'hA0);
        wr(3'd4, 8'h00);

        // R12 chip selects
        wr(3'd1, 8'h09); idle(1);
        check("R12 select line 1", {6'b0, cs_n}, 8'h01);
        wr(3'd1, 8'h01); idle(1);
        check("R12 select line 0", {6'b0, cs_n}, 8'h02);
        wr(3'd0, 8'h3C);
        idle(6);
        wr(3'd1, 8'h02);
        idle(2);
        check("R12 held during byte", {6'b0, cs_n}, 8'h02);
        idle(60);
        check("R12 released after byte", {6'b0, cs_n}, 8'h03);
        rd(3'd0, d);  check("R6 byte during select", d, 8'h3C);

        report();
    end
endmodule